// File: doc/BRIEF.md
# Cascadable Interrupt Controller

The block collects up to 32 interrupt sources into two request lines for a processor core. Each source runs through a two-flop synchroniser. It is then qualified as edge- or level-sensitive, and as active-high (rising) or active-low (falling). A qualifying event sets a sticky status bit. Status bits that are enabled are merged onto a critical or a non-critical request, as chosen per source. Software reads and configures the block through a small word-addressed register port. Reads return data one cycle after the read strobe. Writes take effect on the clock edge that samples the write strobe.

Because the non-critical request is a plain level, it can drive a source input of another instance. Several controllers can be chained this way into a tree. A vector register gives the number of the lowest-numbered pending, enabled source, so a handler can pick its work without scanning.

Top module: `cas_intc`

## Requirements
- R1: Input `src_in[n]` is source n, and source n occupies register bit (31 - n) in every per-source register, so source 0 is bit 31.
- R2: After reset, enable, critical-select, trigger and status read 0, polarity reads all ones (level, active-high), and both request outputs are low.
- R3: Word offsets are status 0x0, enable 0x2, critical-select 0x3, polarity 0x4, trigger 0x5, masked status 0x6 and vector 0x7. Read data appears on `bus_rdata` in the cycle after `bus_rd`, and any other offset reads as zero.
- R4: With trigger bit 1, the status bit sets on a rising edge of the synchronised input when polarity is 1, or on a falling edge when polarity is 0. The opposite transition sets nothing, and the bit stays set after the input returns.
- R5: With trigger bit 0, the status bit sets while the synchronised input is high (polarity 1) or low (polarity 0).
- R6: Writing status clears each bit written as 1 and leaves each bit written as 0. Writing all ones clears every latched edge event.
- R7: A status clear for a level-sensitive source is ignored while its input is still at the active level, whether or not the source is enabled. Once the input is inactive, a clear takes effect.
- R8: Masked status reads as status AND enable. A source whose enable bit is 0 never raises a request.
- R9: Enabled pending sources with critical-select 0 drive `irq_noncrit`, and those with critical-select 1 drive `irq_crit`. Each output is the OR of its group.
- R10: The vector register returns, in bits [4:0], the lowest source number whose masked status is set, with bit 31 as a valid flag. It reads all zero when nothing masked is pending.
- R11: Writes to the masked-status and vector offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 32 | Interrupt source inputs, bit n is source n, asynchronous |
| bus_addr | input | 4 | Register word offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_crit | output | 1 | Critical interrupt request |
| irq_noncrit | output | 1 | Non-critical interrupt request, usable as a cascade input |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are single-cycle strobes with a stable offset. They also assume that each source input holds a level for at least three clock cycles, so that the synchroniser sees every transition. The directed stimulus changes inputs only on falling clock edges and waits four cycles after each change before sampling status. It issues every register access as a one-cycle strobe. Polarity and trigger are always reprogrammed while the affected input sits at its inactive level, so no configuration write creates an unintended event.

// File: rtl/cas_intc_pkg.sv
package cas_intc_pkg;

    localparam int NUM_SRC = 32;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int IDX_W   = $clog2(NUM_SRC);

    localparam logic [ADDR_W-1:0] OFS_STAT  = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_EN    = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_CRIT  = 4'h3;
    localparam logic [ADDR_W-1:0] OFS_POL   = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_TRIG  = 4'h5;
    localparam logic [ADDR_W-1:0] OFS_MSTAT = 4'h6;
    localparam logic [ADDR_W-1:0] OFS_VEC   = 4'h7;

    typedef struct packed {
        logic [NUM_SRC-1:0] en;
        logic [NUM_SRC-1:0] crit;
        logic [NUM_SRC-1:0] pol;
        logic [NUM_SRC-1:0] trig;
        logic [DATA_W-1:0]  rdata;
    } cfg_regs_t;

    // Register bit (DATA_W-1-n) holds source n.
    function automatic logic [NUM_SRC-1:0] flip(input logic [NUM_SRC-1:0] v);
        logic [NUM_SRC-1:0] r;
        for (int i = 0; i < NUM_SRC; i++) begin
            r[i] = v[NUM_SRC-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/cas_intc_sync.sv
module cas_intc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = async_in;
        st_d.sync = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.sync;

endmodule

// File: rtl/cas_intc_status.sv
module cas_intc_status #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_in,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] clr,
    output logic [N-1:0] stat
);

    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] stat;
    } stat_st_t;

    stat_st_t     st_d, st_q;
    logic [N-1:0] event_hit;
    logic [N-1:0] lvl_active;

    for (genvar g = 0; g < N; g++) begin : g_src
        logic active, rise, fall;
        always_comb begin
            active        = pol[g] ? sync_in[g] : ~sync_in[g];
            rise          = sync_in[g] & ~st_q.prev[g];
            fall          = ~sync_in[g] & st_q.prev[g];
            lvl_active[g] = active & ~trig[g];
            if (trig[g]) begin
                event_hit[g] = pol[g] ? rise : fall;
            end else begin
                event_hit[g] = active;
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = sync_in;
        // A new event wins over a clear in the same cycle.
        st_d.stat = event_hit | (st_q.stat & ~clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q.stat;

    AST_LEVEL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(lvl_active) & ~stat) == '0)); // R7

    AST_EDGE_NEEDS_TRANSITION: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & ~$past(stat) & $past(trig) & ~($past(sync_in) ^ $past(sync_in, 2))) == '0)); // R4

endmodule

// File: rtl/cas_intc_prio.sv
module cas_intc_prio #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     pending,
    output logic [IDX_W-1:0] idx,
    output logic             valid
);

    always_comb begin
        idx   = '0;
        valid = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pending[i]) begin
                idx   = IDX_W'(i);
                valid = 1'b1;
            end
        end
    end

    AST_VEC_POINTS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> pending[idx]); // R10

    AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (pending == '0)); // R10

    AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((pending & ~({N{1'b1}} << idx)) == '0)); // R10

endmodule

// File: rtl/cas_intc.sv
module cas_intc
    import cas_intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_crit,
    output logic              irq_noncrit
);

    cfg_regs_t          r_d, r_q;
    logic [NUM_SRC-1:0] sync_src;
    logic [NUM_SRC-1:0] stat;
    logic [NUM_SRC-1:0] clr;
    logic [NUM_SRC-1:0] masked;
    logic [IDX_W-1:0]   vec_idx;
    logic               vec_valid;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  vec_word;

    cas_intc_sync #(.W(NUM_SRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (src_in),
        .sync_out (sync_src)
    );

    cas_intc_status #(.N(NUM_SRC)) u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_src),
        .trig    (r_q.trig),
        .pol     (r_q.pol),
        .clr     (clr),
        .stat    (stat)
    );

    assign masked = stat & r_q.en;

    cas_intc_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) u_prio (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (masked),
        .idx     (vec_idx),
        .valid   (vec_valid)
    );

    always_comb begin
        vec_word              = '0;
        vec_word[DATA_W-1]    = vec_valid;
        vec_word[IDX_W-1:0]   = vec_idx;

        clr = '0;
        if (bus_wr && bus_addr == OFS_STAT) begin
            clr = flip(bus_wdata);
        end

        case (bus_addr)
            OFS_STAT:  rd_mux = flip(stat);
            OFS_EN:    rd_mux = flip(r_q.en);
            OFS_CRIT:  rd_mux = flip(r_q.crit);
            OFS_POL:   rd_mux = flip(r_q.pol);
            OFS_TRIG:  rd_mux = flip(r_q.trig);
            OFS_MSTAT: rd_mux = flip(masked);
            OFS_VEC:   rd_mux = vec_word;
            default:   rd_mux = '0;
        endcase

        r_d = r_q;
        if (bus_wr) begin
            case (bus_addr)
                OFS_EN:   r_d.en   = flip(bus_wdata);
                OFS_CRIT: r_d.crit = flip(bus_wdata);
                OFS_POL:  r_d.pol  = flip(bus_wdata);
                OFS_TRIG: r_d.trig = flip(bus_wdata);
                default:  ;
            endcase
        end
        if (bus_rd) begin
            r_d.rdata = rd_mux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.en    <= '0;
            r_q.crit  <= '0;
            r_q.pol   <= '1;
            r_q.trig  <= '0;
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_rdata   = r_q.rdata;
    assign irq_crit    = |(masked & r_q.crit);
    assign irq_noncrit = |(masked & ~r_q.crit);

    AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == OFS_MSTAT || bus_addr == OFS_VEC)) |=>
        ($stable(r_q.en) && $stable(r_q.crit) && $stable(r_q.pol) && $stable(r_q.trig))); // R11

    AST_NO_IRQ_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en == '0) |-> (!irq_crit && !irq_noncrit)); // R8

    AST_CRIT_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_crit |-> ((r_q.crit & r_q.en) != '0)); // R9

endmodule

// File: tb/cas_intc_bench.sv
module cas_intc_bench;
    import cas_intc_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NUM_SRC-1:0] src_in = '0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_crit, irq_noncrit;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cas_intc u_cas_intc (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_crit(irq_crit), .irq_noncrit(irq_noncrit)
    );

    function automatic logic [31:0] sb(input int n);
        return 32'h8000_0000 >> n;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic tidy();
        @(negedge clk);
        src_in = '0;
        settle();
        wr(4'h2, 32'h0); wr(4'h3, 32'h0); wr(4'h5, 32'h0);
        wr(4'h4, 32'hFFFF_FFFF); wr(4'h0, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R2 irq_crit", {31'b0, irq_crit}, 32'h0);
        check("R2 irq_noncrit", {31'b0, irq_noncrit}, 32'h0);
        rd(4'h2, v); check("R2 enable", v, 32'h0);
        rd(4'h3, v); check("R2 crit", v, 32'h0);
        rd(4'h5, v); check("R2 trigger", v, 32'h0);
        rd(4'h4, v); check("R2 polarity", v, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R2 status", v, 32'h0);
        rd(4'h7, v); check("R2 vector", v, 32'h0);
    endtask

    task automatic t_unimpl();
        logic [31:0] v;
        wr(4'h2, 32'h1234_5678);
        rd(4'h2, v); check("R3 enable readback", v, 32'h1234_5678);
        rd(4'h1, v); check("R3 offset 1", v, 32'h0);
        rd(4'h8, v); check("R3 offset 8", v, 32'h0);
        rd(4'hF, v); check("R3 offset F", v, 32'h0);
        tidy();
    endtask

    task automatic t_edge_rise();
        logic [31:0] v;
        wr(4'h5, sb(3));
        @(negedge clk); src_in[3] = 1'b1; settle();
        rd(4'h0, v); check("R4 R1 rising sets bit 28", v, sb(3));
        @(negedge clk); src_in[3] = 1'b0; settle();
        rd(4'h0, v); check("R4 held after input drops", v, sb(3));
        check("R8 no irq while disabled", {31'b0, irq_noncrit}, 32'h0);
        wr(4'h2, sb(3)); @(negedge clk);
        check("R9 noncrit raised", {30'b0, irq_crit, irq_noncrit}, 32'h1);
        wr(4'h0, sb(3)); @(negedge clk);
        rd(4'h0, v); check("R6 edge cleared", v, 32'h0);
        check("R9 noncrit dropped", {31'b0, irq_noncrit}, 32'h0);
        tidy();
    endtask

    task automatic t_edge_fall();
        logic [31:0] v;
        wr(4'h5, sb(30)); wr(4'h4, ~sb(30));
        @(negedge clk); src_in[30] = 1'b1; settle();
        rd(4'h0, v); check("R4 rising ignored in falling mode", v, 32'h0);
        @(negedge clk); src_in[30] = 1'b0; settle();
        rd(4'h0, v); check("R4 falling sets bit 1", v, sb(30));
        wr(4'h3, sb(30)); wr(4'h2, sb(30)); @(negedge clk);
        check("R9 critical route", {30'b0, irq_crit, irq_noncrit}, 32'h2);
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R6 all ones clears", v, 32'h0);
        tidy();
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(4'h2, sb(7));
        @(negedge clk); src_in[7] = 1'b1; settle();
        rd(4'h0, v); check("R5 level high sets", v, sb(7));
        rd(4'h6, v); check("R8 masked status", v, sb(7));
        check("R9 level noncrit", {31'b0, irq_noncrit}, 32'h1);
        wr(4'h0, sb(7));
        rd(4'h0, v); check("R7 clear ignored while active", v, sb(7));
        wr(4'h2, 32'h0); wr(4'h0, sb(7));
        rd(4'h0, v); check("R7 clear ignored while masked", v, sb(7));
        rd(4'h6, v); check("R8 masked hides", v, 32'h0);
        check("R8 irq low when masked", {31'b0, irq_noncrit}, 32'h0);
        @(negedge clk); src_in[7] = 1'b0; settle();
        rd(4'h0, v); check("R7 bit kept after release", v, sb(7));
        wr(4'h0, sb(7));
        rd(4'h0, v); check("R7 clear after release", v, 32'h0);
        wr(4'h4, ~sb(12)); settle();
        rd(4'h0, v); check("R5 active-low level sets", v, sb(12));
        @(negedge clk); src_in[12] = 1'b1; settle();
        wr(4'h0, sb(12));
        rd(4'h0, v); check("R5 active-low cleared when high", v, 32'h0);
        tidy();
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(4'h5, sb(3) | sb(20));
        @(negedge clk); src_in[3] = 1'b1; src_in[20] = 1'b1; settle();
        wr(4'h0, 32'h0);
        rd(4'h0, v); check("R6 zero write keeps", v, sb(3) | sb(20));
        wr(4'h0, sb(3));
        rd(4'h0, v); check("R6 single clear", v, sb(20));
        tidy();
    endtask

    task automatic t_vector();
        logic [31:0] v;
        wr(4'h5, sb(2) | sb(5) | sb(9));
        wr(4'h2, sb(5) | sb(9));
        @(negedge clk); src_in[2] = 1'b1; src_in[5] = 1'b1; src_in[9] = 1'b1; settle();
        rd(4'h7, v); check("R10 lowest enabled source", v, 32'h8000_0005);
        wr(4'h0, sb(5));
        rd(4'h7, v); check("R10 next source", v, 32'h8000_0009);
        wr(4'h0, sb(9));
        rd(4'h7, v); check("R10 disabled source ignored", v, 32'h0);
        tidy();
    endtask

    task automatic t_ro();
        logic [31:0] v;
        wr(4'h2, 32'h0F0F_0000);
        wr(4'h6, 32'hFFFF_FFFF); wr(4'h7, 32'hFFFF_FFFF);
        rd(4'h2, v); check("R11 enable kept", v, 32'h0F0F_0000);
        rd(4'h3, v); check("R11 crit kept", v, 32'h0);
        rd(4'h4, v); check("R11 polarity kept", v, 32'hFFFF_FFFF);
        rd(4'h5, v); check("R11 trigger kept", v, 32'h0);
        rd(4'h0, v); check("R11 status kept", v, 32'h0);
        tidy();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unimpl();
        t_edge_rise();
        t_edge_fall();
        t_level();
        t_w1c();
        t_vector();
        t_ro();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule